// File: doc/BRIEF.md
# Frame Interrupt Cycle Scheduler

This block keeps the machine-cycle count of a cycle-accurate interpreter core. The core asks it to advance the count by the cost of each instruction through an add request with a ready handshake. The scheduler spreads that amount over as many clocks as it needs. Whenever the count reaches the next frame interrupt point, it stops, charges the interrupt's own cost, and only then counts what is left of the request.

Each interrupt ticks the sound and delay timers down by one, stopping at zero, and raises a one-clock frame strobe that tells the display path to refresh. Frames are 3668 cycles long, and the interrupt sits at a fixed phase inside each frame. The base cost of an interrupt is 1832 cycles. It grows by 4 when the sound timer is nonzero and by 8 when the delay timer is nonzero, and those two tests use the timer values from before the tick. The core can load either timer at any time and reads both back continuously.

The next interrupt point is held in a register. After reset it is ((3250 + 2572) / 3668) * 3668 + 1096 = 4764, and it moves forward by 3668 after each interrupt, so no divider is needed.

Top module: `frame_irq_sched`

## Requirements
- R1: After reset the cycle count is 3250, both timers read 0, frame_strobe is 0 and add_ready is 1.
- R2: A request is accepted in a cycle where add_valid and add_ready are both 1. If no interrupt point lies within the amount, the count has grown by exactly add_amount one clock later. While add_ready is 1 and add_valid is 0, the count does not change.
- R3: The first interrupt point is cycle 4764, and every later point is 3668 cycles after the one before it. The count never passes an interrupt point without the interrupt being taken.
- R4: An interrupt adds 1832 cycles, plus 4 if the sound timer was nonzero and plus 8 if the delay timer was nonzero. Both tests use the timer values held just before the interrupt.
- R5: If a request crosses an interrupt point, the count first stops exactly at that point and the interrupt is inserted. After that the rest of the amount is added, so the final count is start + amount + interrupt cost.
- R6: Each interrupt decrements each nonzero timer by one. A timer that is zero stays at zero.
- R7: frame_strobe is high for exactly one clock per interrupt, in the clock after the interrupt is charged, and is never high for two clocks in a row.
- R8: add_ready is 0 while part of an accepted amount is still to be counted, and while the count has reached the interrupt point but the interrupt has not yet been charged.
- R9: A timer load (snd_load or dly_load) sets that timer to the load value on the next clock. A load takes priority over the interrupt decrement in the same cycle.
- R10: snd_timer and dly_timer always show the current timer values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| add_valid | input | 1 | Request to advance the cycle count |
| add_amount | input | AMT_W | Number of cycles to add |
| add_ready | output | 1 | Scheduler can accept a request |
| snd_load | input | 1 | Load the sound timer |
| snd_load_val | input | TMR_W | Value for the sound timer |
| dly_load | input | 1 | Load the delay timer |
| dly_load_val | input | TMR_W | Value for the delay timer |
| snd_timer | output | TMR_W | Current sound timer |
| dly_timer | output | TMR_W | Current delay timer |
| frame_strobe | output | 1 | One-clock pulse per frame interrupt |
| cycle_count | output | CNT_W | Current machine-cycle count |

## Verification
The assertions check on every cycle that:
- the strobe is a single pulse;
- the strobe follows a cycle in which add_ready was low;
- each strobe comes with a count jump equal to the timer-dependent cost;
- timers saturate at zero and loads take effect;
- the count stays put while idle and never passes the stored interrupt point.

Other properties depend on particular stimulus and are shown only by the bench's scenarios. These are the absolute position of the first interrupt, the split of a crossing request with the remainder counted afterwards, a load winning over a same-cycle decrement, and a request that ends exactly on an interrupt point.

// File: rtl/cs_sched_pkg.sv
package cs_sched_pkg;
    localparam int unsigned FRAME_CYC  = 3668;
    localparam int unsigned IRQ_PHASE  = 1096;
    localparam int unsigned PHASE_LEAD = 2572;
    localparam int unsigned IRQ_BASE   = 1832;
    localparam int unsigned SND_EXTRA  = 4;
    localparam int unsigned DLY_EXTRA  = 8;
    localparam int unsigned BOOT_CYC   = 3250;

    // Interrupt point that follows a given cycle count
    function automatic int unsigned irq_after(input int unsigned c);
        return ((c + PHASE_LEAD) / FRAME_CYC) * FRAME_CYC + IRQ_PHASE;
    endfunction
endpackage

// File: rtl/cs_timer_next.sv
module cs_timer_next #(
    parameter int TMR_W = 8
) (
    input  logic [TMR_W-1:0] cur,
    input  logic             dec,
    input  logic             ld,
    input  logic [TMR_W-1:0] ld_val,
    output logic [TMR_W-1:0] nxt,
    output logic             nonzero
);
    always_comb begin
        nonzero = (cur != '0);
        if (ld)
            nxt = ld_val;
        else if (dec && nonzero)
            nxt = cur - TMR_W'(1);
        else
            nxt = cur;
    end
endmodule

// File: rtl/cs_step_calc.sv
module cs_step_calc #(
    parameter int CNT_W = 32,
    parameter int AMT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] next_irq,
    input  logic [AMT_W-1:0] amount,
    output logic [AMT_W-1:0] step,
    output logic [AMT_W-1:0] rest
);
    logic [CNT_W-1:0] gap;

    always_comb begin
        gap = next_irq - count;
        if (gap < CNT_W'(amount))
            step = gap[AMT_W-1:0];
        else
            step = amount;
        rest = amount - step;
    end
endmodule

// File: rtl/frame_irq_sched.sv
module frame_irq_sched
    import cs_sched_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int AMT_W     = 16,
    parameter int TMR_W     = 8,
    parameter int START_CYC = BOOT_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_valid,
    input  logic [AMT_W-1:0] add_amount,
    output logic             add_ready,
    input  logic             snd_load,
    input  logic [TMR_W-1:0] snd_load_val,
    input  logic             dly_load,
    input  logic [TMR_W-1:0] dly_load_val,
    output logic [TMR_W-1:0] snd_timer,
    output logic [TMR_W-1:0] dly_timer,
    output logic             frame_strobe,
    output logic [CNT_W-1:0] cycle_count
);
    localparam int N_TMR = 2;
    localparam logic [CNT_W-1:0] FRAME_W   = CNT_W'(FRAME_CYC);
    localparam logic [CNT_W-1:0] RST_COUNT = CNT_W'(START_CYC);
    localparam logic [CNT_W-1:0] RST_NEXT  = CNT_W'(irq_after(START_CYC));

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] next_irq;
        logic [AMT_W-1:0] remain;
        logic [TMR_W-1:0] snd;
        logic [TMR_W-1:0] dly;
        logic             strobe;
    } sched_t;

    sched_t s_d, s_q;

    logic             due;
    logic             accept;
    logic [AMT_W-1:0] src;
    logic [AMT_W-1:0] step;
    logic [AMT_W-1:0] rest;
    logic [CNT_W-1:0] cost;
    logic [CNT_W-1:0] next_irq;

    logic [TMR_W-1:0] tmr_cur [N_TMR];
    logic [TMR_W-1:0] tmr_nxt [N_TMR];
    logic [TMR_W-1:0] tmr_val [N_TMR];
    logic             tmr_ld  [N_TMR];
    logic             tmr_nz  [N_TMR];

    assign due       = (s_q.count >= s_q.next_irq);
    assign add_ready = (s_q.remain == '0) && !due;
    assign accept    = add_valid && add_ready;
    assign src       = (s_q.remain != '0) ? s_q.remain : (accept ? add_amount : '0);

    assign tmr_cur[0] = s_q.snd;
    assign tmr_cur[1] = s_q.dly;
    assign tmr_ld[0]  = snd_load;
    assign tmr_ld[1]  = dly_load;
    assign tmr_val[0] = snd_load_val;
    assign tmr_val[1] = dly_load_val;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        cs_timer_next #(.TMR_W(TMR_W)) u_tmr (
            .cur     (tmr_cur[t]),
            .dec     (due),
            .ld      (tmr_ld[t]),
            .ld_val  (tmr_val[t]),
            .nxt     (tmr_nxt[t]),
            .nonzero (tmr_nz[t])
        );
    end

    cs_step_calc #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_step (
        .count    (s_q.count),
        .next_irq (s_q.next_irq),
        .amount   (src),
        .step     (step),
        .rest     (rest)
    );

    assign cost = CNT_W'(IRQ_BASE)
                + (tmr_nz[0] ? CNT_W'(SND_EXTRA) : '0)
                + (tmr_nz[1] ? CNT_W'(DLY_EXTRA) : '0);

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        s_d.snd    = tmr_nxt[0];
        s_d.dly    = tmr_nxt[1];
        if (due) begin
            s_d.count    = s_q.count + cost;
            s_d.next_irq = s_q.next_irq + FRAME_W;
            s_d.strobe   = 1'b1;
        end else begin
            s_d.count  = s_q.count + CNT_W'(step);
            s_d.remain = rest;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count    <= RST_COUNT;
            s_q.next_irq <= RST_NEXT;
            s_q.remain   <= '0;
            s_q.snd      <= '0;
            s_q.dly      <= '0;
            s_q.strobe   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign next_irq     = s_q.next_irq;
    assign cycle_count  = s_q.count;
    assign snd_timer    = s_q.snd;
    assign dly_timer    = s_q.dly;
    assign frame_strobe = s_q.strobe;
endmodule

// File: rtl/frame_irq_sched_chk.sv
module frame_irq_sched_chk #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             add_valid,
    input logic             add_ready,
    input logic             snd_load,
    input logic [TMR_W-1:0] snd_load_val,
    input logic             dly_load,
    input logic [TMR_W-1:0] snd_timer,
    input logic [TMR_W-1:0] dly_timer,
    input logic             frame_strobe,
    input logic [CNT_W-1:0] cycle_count,
    input logic [CNT_W-1:0] next_irq
);
    function automatic logic [CNT_W-1:0] irq_cost(input logic [TMR_W-1:0] s,
                                                  input logic [TMR_W-1:0] d);
        return CNT_W'(1832) + ((s != '0) ? CNT_W'(4) : '0) + ((d != '0) ? CNT_W'(8) : '0);
    endfunction

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    p_irq_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> cycle_count == $past(cycle_count) + irq_cost($past(snd_timer), $past(dly_timer)));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> !$past(add_ready));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_ready && !add_valid) |=> cycle_count == $past(cycle_count));

    p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_count <= next_irq);

    p_snd_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !$past(snd_load)) |->
            snd_timer == (($past(snd_timer) == '0) ? '0 : $past(snd_timer) - TMR_W'(1)));

    p_dly_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !$past(dly_load)) |->
            dly_timer == (($past(dly_timer) == '0) ? '0 : $past(dly_timer) - TMR_W'(1)));

    p_snd_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snd_load |=> snd_timer == $past(snd_load_val));
endmodule

bind frame_irq_sched frame_irq_sched_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .add_valid    (add_valid),
    .add_ready    (add_ready),
    .snd_load     (snd_load),
    .snd_load_val (snd_load_val),
    .dly_load     (dly_load),
    .snd_timer    (snd_timer),
    .dly_timer    (dly_timer),
    .frame_strobe (frame_strobe),
    .cycle_count  (cycle_count),
    .next_irq     (next_irq)
);

// File: tb/sim_frame_irq_sched.sv
module sim_frame_irq_sched;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 32;
    localparam int AMT_W = 16;
    localparam int TMR_W = 8;
    localparam int WATCHDOG = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             add_valid = 1'b0;
    logic [AMT_W-1:0] add_amount = '0;
    logic             add_ready;
    logic             snd_load = 1'b0;
    logic [TMR_W-1:0] snd_load_val = '0;
    logic             dly_load = 1'b0;
    logic [TMR_W-1:0] dly_load_val = '0;
    logic [TMR_W-1:0] snd_timer;
    logic [TMR_W-1:0] dly_timer;
    logic             frame_strobe;
    logic [CNT_W-1:0] cycle_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // behavioural reference
    longint m_count = 3250, m_next = 4764, m_remain = 0;
    int     m_snd = 0, m_dly = 0;
    bit     m_strobe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_irq_sched #(.CNT_W(CNT_W), .AMT_W(AMT_W), .TMR_W(TMR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .add_valid(add_valid), .add_amount(add_amount),
        .add_ready(add_ready), .snd_load(snd_load), .snd_load_val(snd_load_val),
        .dly_load(dly_load), .dly_load_val(dly_load_val), .snd_timer(snd_timer),
        .dly_timer(dly_timer), .frame_strobe(frame_strobe), .cycle_count(cycle_count)
    );

    function automatic bit m_ready();
        return (m_remain == 0) && !(m_count >= m_next);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 3250; m_next = 4764; m_remain = 0;
            m_snd = 0; m_dly = 0; m_strobe = 0;
        end else begin
            longint src, gap, step;
            bit rdy, strobe_n;
            rdy = m_ready();
            strobe_n = 0;
            if (m_count >= m_next) begin
                m_count += 1832 + ((m_snd != 0) ? 4 : 0) + ((m_dly != 0) ? 8 : 0);
                m_next  += 3668;
                if (m_snd > 0) m_snd--;
                if (m_dly > 0) m_dly--;
                strobe_n = 1;
            end else begin
                src = (m_remain != 0) ? m_remain : ((add_valid && rdy) ? longint'(add_amount) : 0);
                gap = m_next - m_count;
                step = (gap < src) ? gap : src;
                m_count += step;
                m_remain = src - step;
            end
            if (snd_load) m_snd = snd_load_val;
            if (dly_load) m_dly = dly_load_val;
            m_strobe = strobe_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(longint'(cycle_count) == m_count, "R2 count vs model", cycle_count, m_count);
            chk(int'(snd_timer) == m_snd, "R6 sound timer vs model", snd_timer, m_snd);
            chk(int'(dly_timer) == m_dly, "R6 delay timer vs model", dly_timer, m_dly);
            chk(frame_strobe == m_strobe, "R7 strobe vs model", frame_strobe, m_strobe);
            chk(add_ready == m_ready(), "R8 ready vs model", add_ready, m_ready());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic do_add(input int amt);
        @(negedge clk);
        while (!add_ready) @(negedge clk);
        add_valid  = 1'b1;
        add_amount = AMT_W'(amt);
        @(negedge clk);
        add_valid  = 1'b0;
    endtask

    task automatic load(input bit s, input int sv, input bit d, input int dv);
        @(negedge clk);
        snd_load = s; snd_load_val = TMR_W'(sv);
        dly_load = d; dly_load_val = TMR_W'(dv);
        @(negedge clk);
        snd_load = 0; dly_load = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!add_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cycle_count == 3250, "R1 reset count", cycle_count, 3250);
        chk(snd_timer == 0 && dly_timer == 0, "R1 reset timers", snd_timer + dly_timer, 0);
        chk(frame_strobe == 0, "R1 reset strobe", frame_strobe, 0);
        chk(add_ready == 1, "R1 reset ready", add_ready, 1);
        rst_n = 1'b1;

        // R2 plain add
        do_add(100);
        chk(cycle_count == 3350, "R2 add 100", cycle_count, 3350);

        // R10 readback after load
        load(1, 3, 1, 5);
        chk(snd_timer == 3 && dly_timer == 5, "R10 readback", {snd_timer, dly_timer}, {8'd3, 8'd5});

        // R5 crossing first point 4764 (R3)
        do_add(2000);
        chk(cycle_count == 4764, "R3 stop at first point", cycle_count, 4764);
        chk(add_ready == 0, "R8 busy with remainder", add_ready, 0);
        @(negedge clk);
        chk(cycle_count == 6608, "R4 cost both nonzero", cycle_count, 6608);
        chk(frame_strobe == 1, "R7 strobe", frame_strobe, 1);
        chk(snd_timer == 2 && dly_timer == 4, "R6 decrement", {snd_timer, dly_timer}, {8'd2, 8'd4});
        @(negedge clk);
        chk(cycle_count == 7194, "R5 remainder added", cycle_count, 7194);
        chk(frame_strobe == 0, "R7 single pulse", frame_strobe, 0);

        // R6 saturation, delay only cost (next point 8432)
        load(1, 0, 1, 1);
        do_add(1300);
        wait_idle();
        chk(cycle_count == 10334, "R4 delay only cost", cycle_count, 10334);
        chk(snd_timer == 0 && dly_timer == 0, "R6 saturate", {snd_timer, dly_timer}, 0);

        // R9 load wins over decrement (next point 12100)
        load(1, 7, 0, 0);
        do_add(2000);
        chk(cycle_count == 12100, "R3 stop at third point", cycle_count, 12100);
        snd_load = 1; snd_load_val = 9;
        @(negedge clk);
        snd_load = 0;
        chk(cycle_count == 13936, "R4 sound only cost", cycle_count, 13936);
        chk(snd_timer == 9, "R9 load over decrement", snd_timer, 9);
        @(negedge clk);
        chk(cycle_count == 14170, "R5 remainder after point", cycle_count, 14170);

        // R8 exact landing on point 15768
        do_add(1598);
        chk(cycle_count == 15768, "R3 exact landing", cycle_count, 15768);
        chk(add_ready == 0, "R8 busy while due", add_ready, 0);
        @(negedge clk);
        chk(cycle_count == 17604, "R4 cost after landing", cycle_count, 17604);
        chk(snd_timer == 8, "R6 decrement after landing", snd_timer, 8);

        // random traffic, checked by model every cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            add_valid    = ($urandom_range(0, 2) != 0);
            add_amount   = AMT_W'($urandom_range(0, 4000));
            snd_load     = ($urandom_range(0, 40) == 0);
            snd_load_val = TMR_W'($urandom_range(0, 3));
            dly_load     = ($urandom_range(0, 40) == 0);
            dly_load_val = TMR_W'($urandom_range(0, 3));
        end
        @(negedge clk);
        add_valid = 0; snd_load = 0; dly_load = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule